// File: doc/BRIEF.md
# Reconfigurable 32-Bit Lookup Storage Cell

This block is a 32-bit storage cell that can take one of three roles. It can be a fixed lookup table (a ROM), a 32x1 RAM with one write port and one read port, or a shift register that can be chained to other cells. Every role uses the same 32 storage bits. The lookup inputs act as a combinational read address in every role. In RAM mode a separate write port has its own address, data and enable, and writes are synchronous. In shift mode each enabled clock pushes the serial input into bit 0. Bit 31 always drives a cascade pin, so several cells can be strung into one longer delay line.

A small mode register picks the role. It loads only on reset or on a configuration strobe. The strobe changes the role but leaves the stored bits alone, so a table loaded as RAM can then be frozen as a ROM. Reset fills the storage from a parameter that holds the initial table.

Top module: `lutmem_cell`

## Requirements
- R1: While `rst` is high, each clock edge loads all 32 storage bits from the parameter `INIT` (bit i of `INIT` goes to address i) and loads the mode register from `cfg_mode`.
- R2: `rd_data` always equals the stored bit at `rd_addr`, with no clock delay. This holds in every mode.
- R3: With mode code 0 (ROM), or the unused code 3, which behaves like ROM, `wr_en` and `shift_en` have no effect and the contents never change.
- R4: With mode code 1 (RAM), a clock edge with `wr_en` high stores `wr_data` at `wr_addr`. All other bits keep their value, and `shift_en` has no effect.
- R5: In RAM mode, when `rd_addr` equals `wr_addr` during a write cycle, `rd_data` shows the old bit before the edge and `wr_data` after it.
- R6: With mode code 2 (shift), a clock edge with `shift_en` high moves bit i to bit i+1 and loads `shift_in` into bit 0. With `shift_en` low the contents hold. `wr_en` has no effect in this mode.
- R7: In shift mode, with `shift_en` high on every edge, `rd_data` at address a equals the `shift_in` value that was sampled a+1 edges earlier.
- R8: `cascade_out` always equals the stored bit at address 31, in every mode.
- R9: The mode register changes only on `rst` or on an edge with `cfg_load` high. The action at that edge follows the old mode, and a `cfg_load` edge leaves the contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Configuration strobe that loads the mode register |
| cfg_mode | input | 2 | Mode code: 0 ROM, 1 RAM, 2 shift, 3 behaves as ROM |
| rd_addr | input | 5 | Lookup inputs, used as the combinational read address or shift tap |
| rd_data | output | 1 | Stored bit at `rd_addr` |
| wr_addr | input | 5 | RAM write address |
| wr_data | input | 1 | RAM write data |
| wr_en | input | 1 | RAM write enable |
| shift_en | input | 1 | Shift enable |
| shift_in | input | 1 | Serial input into bit 0 |
| cascade_out | output | 1 | Bit 31, used for chaining cells |

## Verification
The bench drives writes and shifts in modes where they must be ignored. A cell that leaked either one would show a changed `rd_data` at the touched address. In a same-address write cycle the bench samples `rd_data` both before and after the edge. A registered read, or a write that bypasses onto the read path, would fail one of those two samples. For the shift taps, the bench compares each address against the recorded serial history. An off-by-one in the shift direction or the tap depth would show up as the wrong delay. The bench also loads a new role after filling the RAM with a pattern, which exposes any design that clears or reloads storage on a role change.

// File: rtl/lutmem_pkg.sv
package lutmem_pkg;

    localparam int CELL_DEPTH = 32;
    localparam int CELL_AW    = $clog2(CELL_DEPTH);

    typedef enum logic [1:0] {
        MODE_ROM   = 2'd0,
        MODE_RAM   = 2'd1,
        MODE_SHIFT = 2'd2,
        MODE_RSVD  = 2'd3
    } cell_mode_e;

    typedef struct packed {
        logic               wr_en;
        logic [CELL_AW-1:0] wr_addr;
        logic               wr_data;
        logic               shift_en;
        logic               shift_in;
    } cell_upd_t;

    // Treat the reserved code as a frozen table.
    function automatic cell_mode_e mode_decode(input logic [1:0] code);
        cell_mode_e m;
        m = cell_mode_e'(code);
        if (m == MODE_RSVD) m = MODE_ROM;
        return m;
    endfunction

endpackage

// File: rtl/lutmem_mode_reg.sv
module lutmem_mode_reg
    import lutmem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_load,
    input  logic [1:0] cfg_mode,
    output cell_mode_e mode_q
);

    always_ff @(posedge clk) begin
        if (rst || cfg_load) begin
            mode_q <= mode_decode(cfg_mode);
        end
    end

    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_load |=> $stable(mode_q));

endmodule

// File: rtl/lutmem_store.sv
module lutmem_store
    import lutmem_pkg::*;
#(
    parameter int                  DEPTH = CELL_DEPTH,
    parameter int                  AW    = $clog2(DEPTH),
    parameter logic [DEPTH-1:0]    INIT  = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  cell_mode_e       mode_q,
    input  cell_upd_t        upd,
    output logic [DEPTH-1:0] bits_q
);

    logic [DEPTH-1:0] bits_d;

    for (genvar i = 0; i < DEPTH; i++) begin : g_bit
        logic shift_src;
        if (i == 0) begin : g_head
            assign shift_src = upd.shift_in;
        end else begin : g_body
            assign shift_src = bits_q[i-1];
        end

        always_comb begin
            bits_d[i] = bits_q[i];
            unique case (mode_q)
                MODE_RAM: begin
                    if (upd.wr_en && (upd.wr_addr == AW'(i))) bits_d[i] = upd.wr_data;
                end
                MODE_SHIFT: begin
                    if (upd.shift_en) bits_d[i] = shift_src;
                end
                default: bits_d[i] = bits_q[i];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bits_q <= INIT;
        else     bits_q <= bits_d;
    end

    // R3
    rom_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_ROM) |=> $stable(bits_q));

    // R4
    ram_write_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RAM && upd.wr_en) |=> (bits_q[$past(upd.wr_addr)] == $past(upd.wr_data)));

    // R4
    ram_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RAM && !upd.wr_en) |=> $stable(bits_q));

    // R6
    shift_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SHIFT && !upd.shift_en) |=> $stable(bits_q));

    // R6
    shift_head_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SHIFT && upd.shift_en) |=> (bits_q[0] == $past(upd.shift_in)));

endmodule

// File: rtl/lutmem_read.sv
module lutmem_read
    import lutmem_pkg::*;
#(
    parameter int DEPTH = CELL_DEPTH,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] bits_q,
    input  logic [AW-1:0]    rd_addr,
    output logic             rd_data,
    output logic             cascade_out
);

    assign rd_data     = bits_q[rd_addr];
    assign cascade_out = bits_q[DEPTH-1];

endmodule

// File: rtl/lutmem_cell.sv
module lutmem_cell
    import lutmem_pkg::*;
#(
    parameter logic [CELL_DEPTH-1:0] INIT = 32'hA5C3_0F96
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_load,
    input  logic [1:0]         cfg_mode,
    input  logic [CELL_AW-1:0] rd_addr,
    output logic               rd_data,
    input  logic [CELL_AW-1:0] wr_addr,
    input  logic               wr_data,
    input  logic               wr_en,
    input  logic               shift_en,
    input  logic               shift_in,
    output logic               cascade_out
);

    cell_mode_e            mode_q;
    cell_upd_t             upd;
    logic [CELL_DEPTH-1:0] bits_q;

    assign upd = '{wr_en: wr_en, wr_addr: wr_addr, wr_data: wr_data,
                   shift_en: shift_en, shift_in: shift_in};

    lutmem_mode_reg u_mode (
        .clk      (clk),
        .rst      (rst),
        .cfg_load (cfg_load),
        .cfg_mode (cfg_mode),
        .mode_q   (mode_q)
    );

    lutmem_store #(
        .DEPTH (CELL_DEPTH),
        .AW    (CELL_AW),
        .INIT  (INIT)
    ) u_store (
        .clk    (clk),
        .rst    (rst),
        .mode_q (mode_q),
        .upd    (upd),
        .bits_q (bits_q)
    );

    lutmem_read #(
        .DEPTH (CELL_DEPTH),
        .AW    (CELL_AW)
    ) u_read (
        .bits_q      (bits_q),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .cascade_out (cascade_out)
    );

    // R8
    cascade_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_SHIFT && shift_en) |=> (cascade_out == $past(bits_q[CELL_DEPTH-2])));

    // R9
    cfg_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_load && mode_q == MODE_ROM) |=> $stable(bits_q));

endmodule

// File: tb/lutmem_cell_tb.sv
`timescale 1ns/100ps
module lutmem_cell_tb;

    localparam logic [31:0] INIT_V = 32'hA5C3_0F96;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [4:0] rd_addr = '0;
    logic       rd_data;
    logic [4:0] wr_addr = '0;
    logic       wr_data = 1'b0;
    logic       wr_en = 1'b0;
    logic       shift_en = 1'b0;
    logic       shift_in = 1'b0;
    logic       cascade_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] ref_bits;
    int          ref_mode;
    bit          hist[$];
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    lutmem_cell #(.INIT(INIT_V)) u_dut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
        .rd_addr(rd_addr), .rd_data(rd_data), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_en(wr_en), .shift_en(shift_en),
        .shift_in(shift_in), .cascade_out(cascade_out)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%0d actual=%b expected=%b", req, rd_addr, act, exp);
        end
    endtask

    function automatic logic rnd();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    // One cycle: compare before the edge, update the model, settle at negedge.
    task automatic step(input string req);
        int eff;
        #0.5;
        if (!rst) begin
            check(req, rd_data, ref_bits[rd_addr]);
            check("R8", cascade_out, ref_bits[31]);
            if (ref_mode == 2 && hist.size() > int'(rd_addr))
                check("R7", rd_data, hist[rd_addr]);
        end
        @(posedge clk);
        if (rst) begin
            ref_bits = INIT_V;
            ref_mode = (cfg_mode == 2'd3) ? 0 : int'(cfg_mode);
            hist.delete();
        end else begin
            eff = ref_mode;
            if (eff == 1 && wr_en) ref_bits[wr_addr] = wr_data;
            if (eff == 2 && shift_en) begin
                ref_bits = {ref_bits[30:0], shift_in};
                hist.push_front(shift_in);
            end
            if (cfg_load) begin
                ref_mode = (cfg_mode == 2'd3) ? 0 : int'(cfg_mode);
                hist.delete();
            end
        end
        @(negedge clk);
        #0.5;
    endtask

    task automatic load_mode(input logic [1:0] m);
        cfg_mode = m;
        cfg_load = 1'b1;
        step("R9");
        cfg_load = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1; cfg_mode = 2'd0;
        step("R1");
        step("R1");
        rst = 1'b0;
        // R1 R2: reset table readable at every address
        for (int a = 0; a < 32; a++) begin
            rd_addr = 5'(a);
            step("R1");
        end
        // R3: writes and shifts ignored in ROM
        for (int a = 0; a < 32; a++) begin
            wr_addr = 5'(a); rd_addr = 5'(a); wr_data = ~INIT_V[a];
            wr_en = 1'b1; shift_en = 1'b1; shift_in = rnd();
            step("R3");
        end
        wr_en = 1'b0; shift_en = 1'b0;
        for (int a = 0; a < 32; a++) begin rd_addr = 5'(a); step("R3"); end

        // R9: switch to RAM, contents kept
        wr_en = 1'b1; wr_addr = 5'd4; wr_data = ~INIT_V[4];
        load_mode(2'd1);
        wr_en = 1'b0;
        rd_addr = 5'd4; step("R9");
        // R4: random writes with random reads, shift_en noise
        for (int k = 0; k < 200; k++) begin
            wr_en = rnd(); wr_data = rnd();
            wr_addr = {rnd(), rnd(), rnd(), rnd(), rnd()};
            rd_addr = {rnd(), rnd(), rnd(), rnd(), rnd()};
            shift_en = rnd(); shift_in = rnd();
            step("R4");
        end
        shift_en = 1'b0;
        // R5: same address read/write, old value before edge, new after
        for (int a = 0; a < 32; a += 5) begin
            rd_addr = 5'(a); wr_addr = 5'(a); wr_en = 1'b1;
            wr_data = ~ref_bits[a];
            step("R5");
            wr_en = 1'b0;
            step("R5");
        end
        // R9: freeze as reserved code (ROM behaviour), then back to shift
        load_mode(2'd3);
        wr_en = 1'b1; wr_data = 1'b1; wr_addr = 5'd9; rd_addr = 5'd9;
        step("R3"); step("R3");
        wr_en = 1'b0;
        load_mode(2'd2);
        // R6 R7: continuous shifting with tap sweeps, write noise
        shift_en = 1'b1;
        for (int k = 0; k < 120; k++) begin
            shift_in = rnd(); rd_addr = 5'(k % 32);
            wr_en = rnd(); wr_addr = 5'(k % 32); wr_data = rnd();
            step("R6");
        end
        // R6: gaps with shift_en low
        for (int k = 0; k < 60; k++) begin
            shift_en = rnd(); shift_in = rnd();
            rd_addr = {rnd(), rnd(), rnd(), rnd(), rnd()};
            step("R6");
        end
        shift_en = 1'b0; wr_en = 1'b0;
        for (int a = 0; a < 32; a++) begin rd_addr = 5'(a); step("R2"); end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule